// File: doc/BRIEF.md
# Lane Transmit Character Sequencer

This block produces the octet stream for one lane of a serial converter link, one octet per clock. Its output is a byte plus a control flag that marks the byte as a control character, and it feeds an 8b/10b encoder. While the receiver requests synchronisation, the lane sends only the comma control character. When the request is released, the lane sends a fixed-length alignment sequence that shows the receiver where frames and multiframes begin. After that it sends converter octets.

While sending converter octets, the block replaces some frame-end octets with a control character. This happens when the closing octet of a frame repeats the closing octet of the frame before it. The receiver can then track frame boundaries without extra overhead. If the repeat falls at the close of a multiframe, a separate character is used instead. That multiframe variant can be switched off when the far end cannot synchronise lanes. The sync request can come from a board pin or from a register path, chosen by a select input. Frame length F (octets per frame) and multiframe length K (frames per multiframe) are inputs.

Top module: `lane_tx_seq`

## Requirements
- R1: The effective sync request is `sync_reg_req` when `sync_reg_sel` is 1 and `sync_pin_req` when it is 0. The input that is not selected has no effect.
- R2: Each clock edge at which the effective sync request is 1 makes the next output octet the comma, 8'hBC, with `ctrl_out`=1.
- R3: The first edge with the request at 0 after comma output starts the alignment sequence. The sequence is 4 multiframes of F*K octets each. Within each multiframe, octet 0 is 8'h1C (ctrl 1), the last octet is 8'h7C (ctrl 1), and every other octet is the octet's index within its frame, sent as data (ctrl 0).
- R4: In the second alignment multiframe (index 1), octet 1 of the multiframe is 8'h9C with ctrl 1.
- R5: After the alignment sequence, each output octet is the `data_in` value sampled at the previous edge, with ctrl 0, except where R6 to R8 apply.
- R6: When the last octet of a frame equals the original last octet of the previous frame, and R7 does not apply, it is replaced by 8'hFC with ctrl 1.
- R7: When such a repeat ends a multiframe and `no_lane_sync` is 0, the replacement is 8'h7C with ctrl 1.
- R8: When `no_lane_sync` is 1, no octet in the data phase is ever 8'h7C with ctrl 1. Repeats at multiframe ends become 8'hFC.
- R9: The comparison uses the unreplaced input octet of the previous frame. The first data frame after alignment is never replaced.
- R10: Raising the sync request during alignment or data returns the output to comma on the next octet and restarts the counters.
- R11: During and right after reset, the output is the comma with ctrl 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin_req | input | 1 | Sync request from the board pin, 1 = requested |
| sync_reg_req | input | 1 | Sync request from the register path |
| sync_reg_sel | input | 1 | 1 selects the register path as the sync source |
| frame_len | input | FW | Octets per frame F, nonzero |
| mf_len | input | KW | Frames per multiframe K, nonzero |
| no_lane_sync | input | 1 | 1 = receiver lacks lane synchronisation, so the multiframe variant is not used |
| data_in | input | 8 | Converter octet, consumed every clock in the data phase |
| octet_out | output | 8 | Octet towards the encoder |
| ctrl_out | output | 1 | 1 = `octet_out` is a control character |

## Verification
The bench checks every alignment octet for several F and K shapes, including F=1. A design that placed the 8'h9C marker or the multiframe end wrongly would desynchronise a receiver, and this is where it shows. A table of data octets builds repeats that fall mid-multiframe, at a multiframe end, and right after a replaced frame. This exposes a design that chose the wrong character, that compared against the replaced value, or that replaced octets in the first data frame. Directed steps raise sync in mid-data, switch the sync source, and set `no_lane_sync`. These catch a design that ignored the selected source, acted on the unselected one, or still sent the multiframe character after the flag was set.

// File: rtl/lane_tx_pkg.sv
package lane_tx_pkg;
    localparam logic [7:0] CH_START = 8'h1C;  // K28.0
    localparam logic [7:0] CH_MFEND = 8'h7C;  // K28.3
    localparam logic [7:0] CH_MARK  = 8'h9C;  // K28.4
    localparam logic [7:0] CH_COMMA = 8'hBC;  // K28.5
    localparam logic [7:0] CH_FEND  = 8'hFC;  // K28.7
    localparam int ALIGN_MFS = 4;
    localparam int MFW = $clog2(ALIGN_MFS);

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;
endpackage

// File: rtl/lane_pos_counter.sv
module lane_pos_counter
    import lane_tx_pkg::*;
#(
    parameter int FW = 8,
    parameter int KW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic [FW-1:0]  frame_len,
    input  logic [KW-1:0]  mf_len,
    output logic [FW-1:0]  oct_idx,
    output logic [KW-1:0]  frm_idx,
    output logic [MFW-1:0] mf_idx,
    output logic           frame_end,
    output logic           mf_end
);
    typedef struct packed {
        logic [FW-1:0]  oct;
        logic [KW-1:0]  frm;
        logic [MFW-1:0] mf;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        frame_end = (pos_q.oct == frame_len - FW'(1));
        mf_end    = frame_end && (pos_q.frm == mf_len - KW'(1));
        pos_d     = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (advance) begin
            if (frame_end) begin
                pos_d.oct = '0;
                if (mf_end) begin
                    pos_d.frm = '0;
                    pos_d.mf  = pos_q.mf + MFW'(1);
                end else begin
                    pos_d.frm = pos_q.frm + KW'(1);
                end
            end else begin
                pos_d.oct = pos_q.oct + FW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign oct_idx = pos_q.oct;
    assign frm_idx = pos_q.frm;
    assign mf_idx  = pos_q.mf;

    // R10: a sync request restarts the position from zero
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (oct_idx == '0 && frm_idx == '0 && mf_idx == '0));
endmodule

// File: rtl/lane_align_subst.sv
module lane_align_subst
    import lane_tx_pkg::*;
(
    input  logic [7:0] data_in,
    input  logic [7:0] prev_last,
    input  logic       prev_valid,
    input  logic       frame_end,
    input  logic       mf_end,
    input  logic       no_lane_sync,
    output logic [7:0] sub_octet,
    output logic       sub_ctrl
);
    logic repeat_hit;

    always_comb begin
        repeat_hit = frame_end && prev_valid && (data_in == prev_last);
        sub_octet  = data_in;
        sub_ctrl   = 1'b0;
        if (repeat_hit) begin
            sub_ctrl  = 1'b1;
            sub_octet = (mf_end && !no_lane_sync) ? CH_MFEND : CH_FEND;
        end
    end
endmodule

// File: rtl/lane_tx_seq.sv
module lane_tx_seq
    import lane_tx_pkg::*;
#(
    parameter int FW = 8,
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_pin_req,
    input  logic          sync_reg_req,
    input  logic          sync_reg_sel,
    input  logic [FW-1:0] frame_len,
    input  logic [KW-1:0] mf_len,
    input  logic          no_lane_sync,
    input  logic [7:0]    data_in,
    output logic [7:0]    octet_out,
    output logic          ctrl_out
);
    typedef struct packed {
        phase_e     ph;
        logic [7:0] octet;
        logic       ctrl;
        logic [7:0] prev_last;
        logic       prev_valid;
    } seq_t;

    seq_t st_d, st_q;

    logic           sync_on;
    phase_e         ph_eff;
    logic [FW-1:0]  oct_idx;
    logic [KW-1:0]  frm_idx;
    logic [MFW-1:0] mf_idx;
    logic           frame_end, mf_end;
    logic [7:0]     sub_octet;
    logic           sub_ctrl;
    logic [7:0]     align_octet;
    logic           align_ctrl;
    logic           at_pos0, at_pos1;

    assign sync_on = sync_reg_sel ? sync_reg_req : sync_pin_req;
    assign ph_eff  = (st_q.ph == PH_SYNC) ? PH_ALIGN : st_q.ph;

    lane_pos_counter #(.FW(FW), .KW(KW)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sync_on),
        .advance   (!sync_on),
        .frame_len (frame_len),
        .mf_len    (mf_len),
        .oct_idx   (oct_idx),
        .frm_idx   (frm_idx),
        .mf_idx    (mf_idx),
        .frame_end (frame_end),
        .mf_end    (mf_end)
    );

    lane_align_subst u_subst (
        .data_in      (data_in),
        .prev_last    (st_q.prev_last),
        .prev_valid   (st_q.prev_valid),
        .frame_end    (frame_end),
        .mf_end       (mf_end),
        .no_lane_sync (no_lane_sync),
        .sub_octet    (sub_octet),
        .sub_ctrl     (sub_ctrl)
    );

    // alignment sequence octet for the current position
    always_comb begin
        at_pos0 = (oct_idx == '0) && (frm_idx == '0);
        at_pos1 = ((oct_idx == FW'(1)) && (frm_idx == '0)) ||
                  ((frame_len == FW'(1)) && (frm_idx == KW'(1)) && (oct_idx == '0));
        align_octet = 8'(oct_idx);
        align_ctrl  = 1'b0;
        if (at_pos0) begin
            align_octet = CH_START;
            align_ctrl  = 1'b1;
        end else if (mf_end) begin
            align_octet = CH_MFEND;
            align_ctrl  = 1'b1;
        end else if (at_pos1 && mf_idx == MFW'(1)) begin
            align_octet = CH_MARK;
            align_ctrl  = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (sync_on) begin
            st_d.ph         = PH_SYNC;
            st_d.octet      = CH_COMMA;
            st_d.ctrl       = 1'b1;
            st_d.prev_valid = 1'b0;
        end else if (ph_eff == PH_ALIGN) begin
            st_d.octet      = align_octet;
            st_d.ctrl       = align_ctrl;
            st_d.prev_valid = 1'b0;
            st_d.ph         = (mf_end && mf_idx == MFW'(ALIGN_MFS - 1)) ? PH_DATA : PH_ALIGN;
        end else begin
            st_d.octet = sub_octet;
            st_d.ctrl  = sub_ctrl;
            if (frame_end) begin
                st_d.prev_last  = data_in;
                st_d.prev_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph         <= PH_SYNC;
            st_q.octet      <= CH_COMMA;
            st_q.ctrl       <= 1'b1;
            st_q.prev_last  <= '0;
            st_q.prev_valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign octet_out = st_q.octet;
    assign ctrl_out  = st_q.ctrl;

    p_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_on |=> (octet_out == CH_COMMA && ctrl_out));

    p_align_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_SYNC && !sync_on) |=> (octet_out == CH_START && ctrl_out));

    p_mid_frame_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DATA && !sync_on && !frame_end)
        |=> (!ctrl_out && octet_out == $past(data_in)));

    p_no_mf_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DATA && !sync_on && no_lane_sync)
        |=> !(ctrl_out && octet_out == CH_MFEND));
endmodule

// File: tb/lane_tx_seq_bench.sv
module lane_tx_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_pin_req, sync_reg_req, sync_reg_sel;
    logic [7:0] frame_len;
    logic [4:0] mf_len;
    logic       no_lane_sync;
    logic [7:0] data_in;
    logic [7:0] octet_out;
    logic       ctrl_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lane_tx_seq u_lane_tx_seq (
        .clk(clk), .rst_n(rst_n),
        .sync_pin_req(sync_pin_req), .sync_reg_req(sync_reg_req),
        .sync_reg_sel(sync_reg_sel), .frame_len(frame_len), .mf_len(mf_len),
        .no_lane_sync(no_lane_sync), .data_in(data_in),
        .octet_out(octet_out), .ctrl_out(ctrl_out)
    );

    // {data_in, expected octet, expected ctrl}; F=2, K=2, no_lane_sync=0
    localparam logic [16:0] DVEC [16] = '{
        {8'h11, 8'h11, 1'b0}, {8'h22, 8'h22, 1'b0},  // first frame: R9 no replacement
        {8'h33, 8'h33, 1'b0}, {8'h22, 8'h7C, 1'b1},  // R7 repeat at multiframe end
        {8'h44, 8'h44, 1'b0}, {8'h22, 8'hFC, 1'b1},  // R6, R9 compares unreplaced 22
        {8'h55, 8'h55, 1'b0}, {8'h66, 8'h66, 1'b0},
        {8'h66, 8'h66, 1'b0}, {8'h77, 8'h77, 1'b0},  // R5 repeat not at frame end
        {8'h77, 8'h77, 1'b0}, {8'h88, 8'h88, 1'b0},
        {8'h01, 8'h01, 1'b0}, {8'h88, 8'hFC, 1'b1},  // R6
        {8'h02, 8'h02, 1'b0}, {8'h88, 8'h7C, 1'b1}   // R7
    };

    task automatic chk(input string tag, input logic [7:0] exp_o, input logic exp_c);
        checks++;
        if (octet_out !== exp_o || ctrl_out !== exp_c) begin
            errors++;
            $display("FAIL %s: got octet=%h ctrl=%b expected octet=%h ctrl=%b",
                     tag, octet_out, ctrl_out, exp_o, exp_c);
        end
    endtask

    task automatic hold_sync();
        sync_reg_sel = 1'b0;
        sync_pin_req = 1'b1;
        @(negedge clk);
        chk("R2 comma while sync", 8'hBC, 1'b1);
    endtask

    task automatic run_align(input int f, input int k);
        frame_len    = 8'(f);
        mf_len       = 5'(k);
        sync_pin_req = 1'b0;
        sync_reg_req = 1'b0;
        for (int m = 0; m < 4; m++) begin
            for (int fr = 0; fr < k; fr++) begin
                for (int o = 0; o < f; o++) begin
                    int pos;
                    pos = fr * f + o;
                    @(negedge clk);
                    if (pos == 0)                chk("R3 start", 8'h1C, 1'b1);
                    else if (pos == f * k - 1)   chk("R3 end", 8'h7C, 1'b1);
                    else if (m == 1 && pos == 1) chk("R4 marker", 8'h9C, 1'b1);
                    else                         chk("R3 filler", 8'(o), 1'b0);
                end
            end
        end
    endtask

    task automatic send(input string tag, input logic [7:0] d,
                        input logic [7:0] exp_o, input logic exp_c);
        data_in = d;
        @(negedge clk);
        chk(tag, exp_o, exp_c);
    endtask

    initial begin
        rst_n = 1'b0; sync_pin_req = 1'b1; sync_reg_req = 1'b0; sync_reg_sel = 1'b0;
        frame_len = 8'd2; mf_len = 5'd2; no_lane_sync = 1'b0; data_in = 8'h00;
        repeat (3) @(negedge clk);
        chk("R11 reset comma", 8'hBC, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", 8'hBC, 1'b1);
        hold_sync();

        run_align(2, 2);
        for (int i = 0; i < 16; i++) begin
            logic [16:0] v;
            v = DVEC[i];
            if (v[0] && v[8:1] == 8'h7C)      send("R7 table", v[16:9], v[8:1], v[0]);
            else if (v[0])                    send("R6 table", v[16:9], v[8:1], v[0]);
            else                              send("R5 table", v[16:9], v[8:1], v[0]);
        end

        // R10: sync mid-data
        sync_pin_req = 1'b1;
        send("R10 sync in data", 8'h22, 8'hBC, 1'b1);
        send("R10 sync held", 8'h22, 8'hBC, 1'b1);

        // R8: no lane sync flag
        no_lane_sync = 1'b1;
        run_align(2, 2);
        send("R9 first frame", 8'h7C, 8'h7C, 1'b0);
        send("R9 first frame end", 8'h7C, 8'h7C, 1'b0);
        send("R5 data", 8'h55, 8'h55, 1'b0);
        send("R8 mf end uses FC", 8'h7C, 8'hFC, 1'b1);
        send("R5 data", 8'h66, 8'h66, 1'b0);
        send("R6 repeat", 8'h7C, 8'hFC, 1'b1);
        send("R5 data", 8'h67, 8'h67, 1'b0);
        send("R8 mf end again", 8'h7C, 8'hFC, 1'b1);
        no_lane_sync = 1'b0;

        // R10: sync during alignment
        sync_pin_req = 1'b1;
        @(negedge clk);
        sync_pin_req = 1'b0;
        @(negedge clk);
        chk("R3 restart", 8'h1C, 1'b1);
        sync_pin_req = 1'b1;
        @(negedge clk);
        chk("R10 sync in align", 8'hBC, 1'b1);

        // R1: register path select
        sync_reg_sel = 1'b1; sync_reg_req = 1'b1; sync_pin_req = 1'b0;
        @(negedge clk);
        chk("R1 reg path holds sync", 8'hBC, 1'b1);
        @(negedge clk);
        chk("R1 pin low ignored", 8'hBC, 1'b1);
        sync_reg_req = 1'b0; sync_pin_req = 1'b1;
        @(negedge clk);
        chk("R1 pin high ignored", 8'h1C, 1'b1);
        sync_reg_req = 1'b1;
        @(negedge clk);
        chk("R1 reg reasserts", 8'hBC, 1'b1);
        sync_reg_sel = 1'b0;

        hold_sync();
        run_align(3, 2);
        hold_sync();
        run_align(1, 4);
        send("R9 first frame F1", 8'h5A, 8'h5A, 1'b0);
        send("R6 repeat F1", 8'h5A, 8'hFC, 1'b1);
        send("R5 data F1", 8'h5B, 8'h5B, 1'b0);
        send("R7 mf end F1", 8'h5B, 8'h7C, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule